// File: doc/BRIEF.md
# Synchronous serial port register bank

This block is the processor-facing side of a synchronous serial port. A simple 32-bit register bus reaches six word registers: two control words, a data port, a status word, a clock prescale word and an interrupt status word. Writes to the data port queue transmit frames in an eight-entry FIFO. Reads of the data port drain an eight-entry receive FIFO. Status flags and three interrupt sources report FIFO levels and lost frames.

Only a serial shift engine sits behind the block. The engine takes transmit frames over a valid/ready handshake and hands received frames back with a valid strobe. The block accepts a received frame whenever the port is enabled. If the receive FIFO is full, the frame is dropped and an overrun is flagged. The frame-format word, the prescale value and the mode bits are passed to the engine unchanged, except that the lowest prescale bit is forced to zero.

Bus access: an access occurs in a cycle where `sel_i` is high. `rdata_o` is combinational for the addressed word. Side effects such as the receive pop take place at the closing clock edge. Address bits [1:0] are ignored.

Top module: `ssp_regbank`

## Requirements
- R1: After reset, status reads 0x03, control1 reads 0, `tx_valid_o` is low and all interrupt outputs are low.
- R2: A write to the data word (offset 0x08) queues `wdata_i[15:0]`. Queued frames leave on `tx_data_o` in write order, one per cycle with `tx_valid_o` and `tx_ready_i` both high. A write while eight frames are queued is dropped.
- R3: `tx_valid_o` and `rx_ready_o` are low while the port enable bit (control1 bit 4) is clear. A receive strobe while disabled stores nothing.
- R4: Status (offset 0x0C) bits are: 0 TX empty, 1 TX not full, 2 RX not empty, 3 RX full, 4 busy.
- R5: A read of the data word returns the oldest received frame and removes it. A read from an empty receive FIFO returns 0 and changes no state.
- R6: Control0[3:0] holds frame bits minus one. Received data is read right-justified, with bits above the frame width returned as zero.
- R7: A frame accepted while the receive FIFO is full is dropped and the overrun flag sets. The flag appears as interrupt status bit 2 and drives `irq_ovr_o` when control1 bit 2 is set.
- R8: Any write to offset 0x14 clears the overrun flag.
- R9: The RX interrupt (status bit 0, `irq_rx_o`) is high when at least 4 frames are held and control1 bit 0 is set. The TX interrupt (bit 1, `irq_tx_o`) is high when at most 4 frames are queued and control1 bit 1 is set.
- R10: Control0 (0x00) stores 16 bits, control1 (0x04) stores 7 bits, and prescale (0x10) stores 8 bits with bit 0 reading as 0. All three read back and drive the configuration outputs. Control1 bit 3 is loopback, bit 5 is slave mode and bit 6 is slave output disable.
- R11: Busy is set when the port is enabled and either `busy_i` is high or the TX FIFO is not empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Bus access strobe |
| we_i | input | 1 | Write when high, read when low |
| addr_i | input | AW (5) | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for the addressed word |
| tx_valid_o | output | 1 | Transmit frame available |
| tx_ready_i | input | 1 | Engine takes the transmit frame |
| tx_data_o | output | DW (16) | Head transmit frame |
| rx_valid_i | input | 1 | Received frame strobe |
| rx_ready_o | output | 1 | Receive path accepting frames |
| rx_data_i | input | DW (16) | Received frame |
| busy_i | input | 1 | Engine shifting a frame |
| port_en_o | output | 1 | Port enable |
| loopback_o | output | 1 | Loopback mode |
| slave_mode_o | output | 1 | Slave mode select |
| slave_od_o | output | 1 | Slave output disable |
| frame_cfg_o | output | 16 | Control0 contents |
| prescale_o | output | 8 | Clock prescale, always even |
| irq_rx_o | output | 1 | Receive level interrupt |
| irq_tx_o | output | 1 | Transmit level interrupt |
| irq_ovr_o | output | 1 | Receive overrun interrupt |
| irq_o | output | 1 | OR of the three interrupts |

## Verification
The checks assume that the engine holds no transmit frame outside the handshake: the head frame must stay constant while it is offered and not taken. They also assume that a receive strobe is a single-cycle event. The stimulus drives all bus and engine inputs on the falling edge. Each bus access and each receive strobe lasts exactly one rising edge. The bench plays the shift engine itself, and raises `tx_ready_i` only in cycles where it has first compared the offered frame.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  localparam int CFG_W = 16;
  localparam int PRE_W = 8;

  // word indices (byte offset / 4)
  localparam logic [2:0] W_CTRL0 = 3'd0;
  localparam logic [2:0] W_CTRL1 = 3'd1;
  localparam logic [2:0] W_DATA  = 3'd2;
  localparam logic [2:0] W_STAT  = 3'd3;
  localparam logic [2:0] W_PRE   = 3'd4;
  localparam logic [2:0] W_ISR   = 3'd5;

  typedef struct packed {
    logic slave_od;  // bit 6
    logic slave;     // bit 5
    logic en;        // bit 4
    logic lbk;       // bit 3
    logic ovr_ie;    // bit 2
    logic tx_ie;     // bit 1
    logic rx_ie;     // bit 0
  } ctrl1_t;

  typedef struct packed {
    logic busy;      // bit 4
    logic rx_full;   // bit 3
    logic rx_nempty; // bit 2
    logic tx_nfull;  // bit 1
    logic tx_empty;  // bit 0
  } stat_t;
endpackage

// File: rtl/ssp_fifo.sv
module ssp_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 8,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          pop_i,
  output logic [W-1:0]  rdata_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop;

  assign full_o  = (count_o == CW'(DEPTH));
  assign empty_o = (count_o == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign rdata_o = mem[rd_ptr];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count_o <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count_o <= count_o + 1'b1;
        2'b01:   count_o <= count_o - 1'b1;
        default: count_o <= count_o;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wr_ptr] <= wdata_i;
  end
endmodule

// File: rtl/ssp_irq.sv
module ssp_irq #(
  parameter int CW     = 4,
  parameter int RX_THR = 4,
  parameter int TX_THR = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] rx_count_i,
  input  logic [CW-1:0] tx_count_i,
  input  logic [2:0]    ie_i,     // {ovr, tx, rx}
  input  logic          ovr_set_i,
  input  logic          ovr_clr_i,
  output logic [2:0]    irq_o,    // {ovr, tx, rx}, masked
  output logic          ovr_flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ovr_flag_o <= 1'b0;
    else if (ovr_set_i) ovr_flag_o <= 1'b1;  // new loss beats a clear
    else if (ovr_clr_i) ovr_flag_o <= 1'b0;
  end

  assign irq_o[0] = ie_i[0] && (rx_count_i >= CW'(RX_THR));
  assign irq_o[1] = ie_i[1] && (tx_count_i <= CW'(TX_THR));
  assign irq_o[2] = ie_i[2] && ovr_flag_o;
endmodule

// File: rtl/ssp_regbank.sv
module ssp_regbank
  import ssp_pkg::*;
#(
  parameter int AW     = 5,
  parameter int DW     = 16,
  parameter int DEPTH  = 8,
  parameter int RX_THR = 4,
  parameter int TX_THR = 4,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_i,
  input  logic             we_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [31:0]      wdata_i,
  output logic [31:0]      rdata_o,
  output logic             tx_valid_o,
  input  logic             tx_ready_i,
  output logic [DW-1:0]    tx_data_o,
  input  logic             rx_valid_i,
  output logic             rx_ready_o,
  input  logic [DW-1:0]    rx_data_i,
  input  logic             busy_i,
  output logic             port_en_o,
  output logic             loopback_o,
  output logic             slave_mode_o,
  output logic             slave_od_o,
  output logic [CFG_W-1:0] frame_cfg_o,
  output logic [PRE_W-1:0] prescale_o,
  output logic             irq_rx_o,
  output logic             irq_tx_o,
  output logic             irq_ovr_o,
  output logic             irq_o
);
  logic [CFG_W-1:0] ctrl0_q;
  ctrl1_t           ctrl1_q;
  logic [PRE_W-1:0] pre_q;
  logic [2:0]       word;
  logic             wr, rd;
  logic             tx_push, tx_pop, tx_full, tx_empty;
  logic             rx_push, rx_pop, rx_full, rx_empty;
  logic [DW-1:0]    rx_head;
  logic [CW-1:0]    tx_count, rx_count;
  logic             ovr_set, ovr_clr, ovr_flag;
  logic [2:0]       irq_vec;
  stat_t            stat;
  logic [DW:0]      width_mask;
  logic             unused_ok;

  assign word = addr_i[4:2];
  assign wr   = sel_i && we_i;
  assign rd   = sel_i && !we_i;
  assign unused_ok = ^{addr_i[1:0], wdata_i[31:CFG_W]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl0_q <= '0;
      ctrl1_q <= '0;
      pre_q   <= '0;
    end else if (wr) begin
      case (word)
        W_CTRL0: ctrl0_q <= wdata_i[CFG_W-1:0];
        W_CTRL1: ctrl1_q <= ctrl1_t'(wdata_i[6:0]);
        W_PRE:   pre_q   <= {wdata_i[PRE_W-1:1], 1'b0};
        default: ;
      endcase
    end
  end

  // engine handshake, gated by port enable
  assign tx_valid_o = ctrl1_q.en && !tx_empty;
  assign rx_ready_o = ctrl1_q.en;
  assign tx_pop     = tx_valid_o && tx_ready_i;
  assign tx_push    = wr && (word == W_DATA);
  assign rx_push    = rx_valid_i && rx_ready_o;
  assign rx_pop     = rd && (word == W_DATA);
  assign ovr_set    = rx_push && rx_full;
  assign ovr_clr    = wr && (word == W_ISR);

  ssp_fifo #(.W(DW), .DEPTH(DEPTH)) u_tx_fifo (
    .clk_i, .rst_ni,
    .push_i(tx_push), .wdata_i(wdata_i[DW-1:0]), .pop_i(tx_pop),
    .rdata_o(tx_data_o), .count_o(tx_count), .full_o(tx_full), .empty_o(tx_empty)
  );

  ssp_fifo #(.W(DW), .DEPTH(DEPTH)) u_rx_fifo (
    .clk_i, .rst_ni,
    .push_i(rx_push), .wdata_i(rx_data_i), .pop_i(rx_pop),
    .rdata_o(rx_head), .count_o(rx_count), .full_o(rx_full), .empty_o(rx_empty)
  );

  ssp_irq #(.CW(CW), .RX_THR(RX_THR), .TX_THR(TX_THR)) u_irq (
    .clk_i, .rst_ni,
    .rx_count_i(rx_count), .tx_count_i(tx_count),
    .ie_i({ctrl1_q.ovr_ie, ctrl1_q.tx_ie, ctrl1_q.rx_ie}),
    .ovr_set_i(ovr_set), .ovr_clr_i(ovr_clr),
    .irq_o(irq_vec), .ovr_flag_o(ovr_flag)
  );

  assign stat.tx_empty  = tx_empty;
  assign stat.tx_nfull  = !tx_full;
  assign stat.rx_nempty = !rx_empty;
  assign stat.rx_full   = rx_full;
  assign stat.busy      = ctrl1_q.en && (busy_i || !tx_empty);

  // frame width = ctrl0[3:0] + 1
  assign width_mask = ({{DW{1'b0}}, 1'b1} << ({1'b0, ctrl0_q[3:0]} + 5'd1)) - 1'b1;

  always_comb begin
    rdata_o = '0;
    case (word)
      W_CTRL0: rdata_o = {{(32-CFG_W){1'b0}}, ctrl0_q};
      W_CTRL1: rdata_o = {25'b0, ctrl1_q};
      W_DATA:  rdata_o = rx_empty ? '0 : {{(32-DW){1'b0}}, rx_head & width_mask[DW-1:0]};
      W_STAT:  rdata_o = {27'b0, stat};
      W_PRE:   rdata_o = {{(32-PRE_W){1'b0}}, pre_q};
      W_ISR:   rdata_o = {29'b0, irq_vec};
      default: rdata_o = '0;
    endcase
  end

  assign port_en_o    = ctrl1_q.en;
  assign loopback_o   = ctrl1_q.lbk;
  assign slave_mode_o = ctrl1_q.slave;
  assign slave_od_o   = ctrl1_q.slave_od;
  assign frame_cfg_o  = ctrl0_q;
  assign prescale_o   = pre_q;
  assign irq_rx_o     = irq_vec[0];
  assign irq_tx_o     = irq_vec[1];
  assign irq_ovr_o    = irq_vec[2];
  assign irq_o        = |irq_vec;
endmodule

// File: rtl/ssp_regbank_chk.sv
module ssp_regbank_chk #(
  parameter int DW = 16,
  parameter int CW = 4,
  parameter int DEPTH = 8,
  parameter int RX_THR = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          tx_valid_o,
  input logic          tx_ready_i,
  input logic [DW-1:0] tx_data_o,
  input logic          port_en_o,
  input logic          irq_rx_o,
  input logic [CW-1:0] rx_count,
  input logic          ovr_set,
  input logic          ovr_clr,
  input logic          ovr_flag
);
  p_tx_gate_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !port_en_o |-> !tx_valid_o);

  p_tx_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ready_i) |=> $stable(tx_data_o));

  p_rx_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_count <= CW'(DEPTH));

  p_ovr_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_set |=> ovr_flag);

  p_ovr_clr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_clr && !ovr_set) |=> !ovr_flag);

  p_rx_irq_lvl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_rx_o |-> (rx_count >= CW'(RX_THR)));
endmodule

bind ssp_regbank ssp_regbank_chk #(.DW(DW), .CW(CW), .DEPTH(DEPTH), .RX_THR(RX_THR)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .tx_valid_o(tx_valid_o), .tx_ready_i(tx_ready_i), .tx_data_o(tx_data_o),
  .port_en_o(port_en_o), .irq_rx_o(irq_rx_o), .rx_count(rx_count),
  .ovr_set(ovr_set), .ovr_clr(ovr_clr), .ovr_flag(ovr_flag)
);

// File: tb/ssp_regbank_bench.sv
module ssp_regbank_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sel = 1'b0, we = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        tx_valid, tx_ready = 1'b0;
  logic [15:0] tx_data;
  logic        rx_valid = 1'b0, rx_ready;
  logic [15:0] rx_data = '0;
  logic        busy = 1'b0;
  logic        port_en, lbk, slv, slv_od;
  logic [15:0] frame_cfg;
  logic [7:0]  prescale;
  logic        irq_rx, irq_tx, irq_ovr, irq_any;
  int          n_tests = 0, n_fail = 0;

  always #10 clk = ~clk;  // 50 MHz

  ssp_regbank u_ssp_regbank (
    .clk_i(clk), .rst_ni(rst_ni), .sel_i(sel), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .tx_valid_o(tx_valid), .tx_ready_i(tx_ready),
    .tx_data_o(tx_data), .rx_valid_i(rx_valid), .rx_ready_o(rx_ready),
    .rx_data_i(rx_data), .busy_i(busy), .port_en_o(port_en), .loopback_o(lbk),
    .slave_mode_o(slv), .slave_od_o(slv_od), .frame_cfg_o(frame_cfg),
    .prescale_o(prescale), .irq_rx_o(irq_rx), .irq_tx_o(irq_tx),
    .irq_ovr_o(irq_ovr), .irq_o(irq_any)
  );

  localparam logic [4:0] A_C0 = 5'h00, A_C1 = 5'h04, A_DAT = 5'h08,
                         A_ST = 5'h0C, A_PRE = 5'h10, A_ISR = 5'h14;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); sel = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk); sel = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); sel = 1'b1; we = 1'b0; addr = a;
    #2 d = rdata;
    @(negedge clk); sel = 1'b0;
  endtask

  task automatic rx_push(input logic [15:0] d);
    @(negedge clk); rx_valid = 1'b1; rx_data = d;
    @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic tx_take(input string req, input logic [15:0] exp);
    @(negedge clk);
    check(req, {31'b0, tx_valid}, 32'd1);
    check(req, {16'b0, tx_data}, {16'b0, exp});
    tx_ready = 1'b1;
    @(negedge clk); tx_ready = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(A_ST, v);  check("R1 status", v, 32'h03);
    rd(A_C1, v);  check("R1 ctrl1", v, 32'h0);
    check("R1 irq", {28'b0, irq_rx, irq_tx, irq_ovr, irq_any}, 32'h0);
    check("R1 tx_valid", {31'b0, tx_valid}, 32'h0);
  endtask

  task automatic t_ctrl();
    logic [31:0] v;
    wr(A_C0, 32'h1234_ABCD); rd(A_C0, v); check("R10 ctrl0", v, 32'hABCD);
    check("R10 frame_cfg_o", {16'b0, frame_cfg}, 32'hABCD);
    wr(A_C1, 32'hFFFF_FF68); rd(A_C1, v); check("R10 ctrl1", v, 32'h68);
    check("R10 mode outs", {28'b0, slv_od, slv, port_en, lbk}, 32'hD);
    wr(A_PRE, 32'h37); rd(A_PRE, v); check("R10 prescale even", v, 32'h36);
    check("R10 prescale_o", {24'b0, prescale}, 32'h36);
    wr(A_C1, 32'h0);
  endtask

  task automatic t_tx_order();
    logic [31:0] v;
    for (int i = 0; i < 3; i++) wr(A_DAT, 32'hA0 + i);
    @(negedge clk);
    check("R3 tx gated", {31'b0, tx_valid}, 32'h0);
    rd(A_ST, v); check("R4 status 3 queued disabled", v, 32'h02);
    wr(A_C1, 32'h10);
    rd(A_ST, v); check("R11 busy from queue", v, 32'h12);
    for (int i = 0; i < 3; i++) tx_take("R2 tx order", 16'hA0 + 16'(i));
    rd(A_ST, v); check("R4 status drained", v, 32'h03);
  endtask

  task automatic t_tx_full();
    logic [31:0] v;
    for (int i = 0; i < 10; i++) wr(A_DAT, 32'h0F00 + i);
    rd(A_ST, v); check("R4 tx full", v, 32'h10);
    for (int i = 0; i < 8; i++) tx_take("R2 tx full order", 16'h0F00 + 16'(i));
    @(negedge clk);
    check("R2 extra frames dropped", {31'b0, tx_valid}, 32'h0);
  endtask

  task automatic t_tx_irq();
    logic [31:0] v;
    wr(A_C1, 32'h12);
    check("R9 tx irq empty", {31'b0, irq_tx}, 32'h1);
    for (int i = 0; i < 5; i++) wr(A_DAT, 32'h50 + i);
    check("R9 tx irq 5 queued", {31'b0, irq_tx}, 32'h0);
    rd(A_ISR, v); check("R9 isr 5 queued", v, 32'h0);
    tx_take("R2 tx irq frame", 16'h50);
    check("R9 tx irq 4 queued", {31'b0, irq_tx}, 32'h1);
    rd(A_ISR, v); check("R9 isr 4 queued", v, 32'h2);
    for (int i = 1; i < 5; i++) tx_take("R2 tx irq drain", 16'h50 + 16'(i));
  endtask

  task automatic t_rx();
    logic [31:0] v;
    wr(A_C0, 32'h0F); wr(A_C1, 32'h11);
    for (int i = 0; i < 3; i++) rx_push(16'hC000 + 16'(i));
    check("R9 rx irq 3 held", {31'b0, irq_rx}, 32'h0);
    rx_push(16'hC003);
    check("R9 rx irq 4 held", {31'b0, irq_rx}, 32'h1);
    rd(A_ST, v); check("R4 rx not empty", v, 32'h07);
    for (int i = 0; i < 4; i++) begin
      rd(A_DAT, v); check("R5 rx order", v, 32'hC000 + i);
    end
    rd(A_DAT, v); check("R5 empty read zero", v, 32'h0);
    rd(A_ST, v); check("R5 empty read no change", v, 32'h03);
  endtask

  task automatic t_width();
    logic [31:0] v;
    wr(A_C0, 32'h07); rx_push(16'hABCD);
    rd(A_DAT, v); check("R6 8-bit frame", v, 32'hCD);
    wr(A_C0, 32'h03); rx_push(16'hFFFF);
    rd(A_DAT, v); check("R6 4-bit frame", v, 32'hF);
  endtask

  task automatic t_rx_disabled();
    logic [31:0] v;
    wr(A_C1, 32'h0);
    check("R3 rx_ready low", {31'b0, rx_ready}, 32'h0);
    rx_push(16'h1234);
    rd(A_ST, v); check("R3 rx ignored", v, 32'h03);
  endtask

  task automatic t_overrun();
    logic [31:0] v;
    wr(A_C0, 32'h0F); wr(A_C1, 32'h14);
    for (int i = 0; i < 8; i++) rx_push(16'h0100 + 16'(i));
    rd(A_ST, v); check("R4 rx full", v, 32'h0F);
    check("R7 no overrun yet", {31'b0, irq_ovr}, 32'h0);
    rx_push(16'h0DEA);
    check("R7 overrun irq", {31'b0, irq_ovr}, 32'h1);
    rd(A_ISR, v); check("R7 isr overrun", v, 32'h4);
    for (int i = 0; i < 8; i++) begin
      rd(A_DAT, v); check("R7 kept frames", v, 32'h0100 + i);
    end
    rd(A_DAT, v); check("R7 dropped frame absent", v, 32'h0);
    wr(A_ISR, 32'h0);
    check("R8 overrun cleared", {31'b0, irq_ovr}, 32'h0);
    rd(A_ISR, v); check("R8 isr cleared", v, 32'h0);
  endtask

  task automatic t_busy();
    logic [31:0] v;
    wr(A_C1, 32'h10); busy = 1'b1;
    rd(A_ST, v); check("R11 busy from engine", v, 32'h13);
    wr(A_C1, 32'h0);
    rd(A_ST, v); check("R11 busy needs enable", v, 32'h03);
    busy = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_ctrl();
    t_tx_order();
    t_tx_full();
    t_tx_irq();
    t_rx();
    t_width();
    t_rx_disabled();
    t_overrun();
    t_busy();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule